// File: doc/BRIEF.md
# Dual-Channel Edge-Aligned PWM Timer

This block holds two timer channels. Each one can drive an 8-bit edge-aligned pulse width modulated output. Each channel has three parts:
- a prescaler whose active width can be programmed from 1 to 8 bits;
- an 8-bit main counter that steps once each time the prescaler rolls over;
- a compare value that sets how long the output stays high in each counter period.

The channels count only the internal clock. They never count events on a pin.

Software writes one shared control byte and one compare value per channel, all through a single write port. The control byte holds, for each channel, a PWM enable bit and a 3-bit prescaler width field. A compare write goes into a shadow register. The value moves into the active compare register only when the counter wraps from 0xFF to 0x00, so a period is never cut short or stretched. Each channel also has a run enable and a gate. When gating is on and the gate input is low, counting stops and the output level is held.

Each channel gives a one-cycle overflow pulse on every counter wrap, whether or not PWM is enabled. The output starts each period high and drops when the counter reaches the active compare value.

Top module: `pwm_timer_pair`

## Requirements
- R1: After reset both outputs and both overflow pulses are low, and the control byte holds 0x24. Both prescaler fields are therefore binary 100, giving 5 active bits and an overflow period of 8192 clock cycles.
- R2: A write to address 0 loads the control byte:
  - bit 7 is the PWM enable of channel 1 and bit 6 that of channel 0;
  - bits 5:3 are the prescaler field of channel 1 and bits 2:0 that of channel 0.
  
  A write to address 1 loads the compare shadow of channel 0, and a write to address 2 loads that of channel 1.
- R3: With prescaler field value f, the prescaler uses f+1 bits. The main counter advances once per 2^(f+1) counting cycles, so the overflow period is 256*2^(f+1) cycles.
- R4: With PWM enabled and active compare C not 0, the output is high for C*2^(f+1) cycles and low for the rest of the period. The high stretch begins in the cycle in which the overflow pulse is high.
- R5: An active compare value of 0x00 keeps the output low for the whole period.
- R6: A compare write takes effect at the next 0xFF to 0x00 wrap. A write that lands on the same clock edge as a wrap takes effect at the wrap after that one.
- R7: The overflow pulse is high for exactly one cycle after each wrap, whether PWM is enabled or not.
- R8: With its PWM enable clear, a channel's output is low while its counter keeps running and its overflow pulse keeps occurring.
- R9: When a channel's gate enable is high and its gate input is low:
  - counting stops;
  - the output holds its level;
  - no overflow pulse occurs.
  
  With the gate enable low, the gate input has no effect.
- R10: When a channel's run enable is low, counting stops, the output holds its level and no overflow pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 2 | Per-channel counting enable |
| gate_en | input | 2 | Per-channel gating enable |
| gate_in | input | 2 | Per-channel external gate level; counting is allowed while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 compare 0, 2 compare 1 |
| wr_data | input | 8 | Write data |
| pwm_out | output | 2 | Per-channel PWM output level |
| ovf_pulse | output | 2 | Per-channel one-cycle wrap pulse |

## Verification
A compare write and a counter wrap can land on the same clock edge. The bench uses the overflow pulse to find the period phase. It then places a compare write on the exact edge of the next wrap, and in a second case one cycle before it. For each period in turn it counts the high cycles. A write on the wrap edge must leave the next period at the old duty and change the period after it. A write one cycle earlier must change the very next period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NCH       = 2;
  localparam int SEL_W     = 3;
  localparam int CTRL_W    = NCH * (1 + SEL_W);
  localparam int EN_LSB    = NCH * SEL_W;
  localparam int ADDR_W    = 2;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h24;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMP0 = 2'd1,
    ADDR_CMP1 = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int MAX_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [SEL_W-1:0] sel,
  output logic             roll
);
  logic [MAX_W-1:0] cnt_q;
  logic [MAX_W-1:0] mask;

  // bit i is active when i <= sel, so sel+1 bits count
  always_comb begin
    for (int i = 0; i < MAX_W; i++) begin
      mask[i] = (i <= int'(sel));
    end
  end

  assign roll = advance && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (advance) begin
      cnt_q <= (cnt_q + 1'b1) & mask;
    end
  end
endmodule

// File: rtl/pwm_cmp_buffer.sv
module pwm_cmp_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         swap,
  output logic [W-1:0] active_q,
  output logic [W-1:0] active_nx
);
  logic [W-1:0] shadow_q;

  // a load and a swap on the same edge: active takes the old shadow
  assign active_nx = swap ? shadow_q : active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (load) shadow_q <= din;
      active_q <= active_nx;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W     = 8,
  parameter int MAX_PSC_W = 8,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ok,
  input  logic             pwm_en,
  input  logic [SEL_W-1:0] psc_sel,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_din,
  output logic             pwm_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] act_cmp_o
);
  logic             roll;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] act_nx;
  logic             lvl_q;
  logic             ovf_q;

  pwm_prescaler #(.MAX_W(MAX_PSC_W), .SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst(rst), .advance(tick_ok), .sel(psc_sel), .roll(roll)
  );

  assign cnt_nx = cnt_q + 1'b1;
  assign wrap   = roll && (&cnt_q);

  pwm_cmp_buffer #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .load(cmp_we), .din(cmp_din), .swap(wrap),
    .active_q(act_cmp_o), .active_nx(act_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (roll) cnt_q <= cnt_nx;
      ovf_q <= wrap;
    end
  end

  // reaching the compare value wins over the period start, so compare 0 keeps it low
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
    end else if (!pwm_en) begin
      lvl_q <= 1'b0;
    end else if (roll) begin
      if (cnt_nx == act_nx)  lvl_q <= 1'b0;
      else if (cnt_nx == '0) lvl_q <= 1'b1;
    end
  end

  assign pwm_o = lvl_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/pwm_timer_pair.sv
module pwm_timer_pair
  import pwm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_PSC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    run_en,
  input  logic [NCH-1:0]    gate_en,
  input  logic [NCH-1:0]    gate_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    ovf_pulse
);
  logic [CTRL_W-1:0]           ctrl_q;
  logic [NCH-1:0][CNT_W-1:0]   act_cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_en && (wr_addr == ADDR_CTRL)) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic tick_ok;
    logic cmp_we;

    assign tick_ok = run_en[ch] && (!gate_en[ch] || gate_in[ch]);
    assign cmp_we  = wr_en && (wr_addr == ADDR_W'(ch + 1));

    pwm_channel #(.CNT_W(CNT_W), .MAX_PSC_W(MAX_PSC_W), .SEL_W(SEL_W)) u_chan (
      .clk(clk),
      .rst(rst),
      .tick_ok(tick_ok),
      .pwm_en(ctrl_q[EN_LSB + ch]),
      .psc_sel(ctrl_q[ch*SEL_W +: SEL_W]),
      .cmp_we(cmp_we),
      .cmp_din(wr_data),
      .pwm_o(pwm_out[ch]),
      .ovf_o(ovf_pulse[ch]),
      .act_cmp_o(act_cmp[ch])
    );
  end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NCH-1:0]           run_en,
  input logic [NCH-1:0]           gate_en,
  input logic [NCH-1:0]           gate_in,
  input logic [NCH-1:0]           pwm_en,
  input logic [NCH-1:0][CNT_W-1:0] act_cmp,
  input logic [NCH-1:0]           pwm_out,
  input logic [NCH-1:0]           ovf_pulse
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R7
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_pulse[i] |=> !ovf_pulse[i]);

    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      !pwm_en[i] |=> !pwm_out[i]);

    // R5
    zero_cmp_low_chk: assert property (@(posedge clk) disable iff (rst)
      (act_cmp[i] == '0) |-> !pwm_out[i]);

    // R6
    cmp_swap_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(act_cmp[i]) |-> ovf_pulse[i]);

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (gate_en[i] && !gate_in[i] && pwm_en[i]) |=> ($stable(pwm_out[i]) && !ovf_pulse[i]));

    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_en[i] && pwm_en[i]) |=> ($stable(pwm_out[i]) && !ovf_pulse[i]));
  end
endmodule

bind pwm_timer_pair pwm_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .run_en(run_en),
  .gate_en(gate_en),
  .gate_in(gate_in),
  .pwm_en(ctrl_q[pwm_pkg::EN_LSB +: pwm_pkg::NCH]),
  .act_cmp(act_cmp),
  .pwm_out(pwm_out),
  .ovf_pulse(ovf_pulse)
);

// File: tb/sim_pwm_timer_pair.sv
`timescale 1ns/1ps
module sim_pwm_timer_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] run_en  = 2'b11;
  logic [1:0] gate_en = 2'b00;
  logic [1:0] gate_in = 2'b11;
  logic       wr_en   = 1'b0;
  logic [1:0] wr_addr = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] pwm_out;
  logic [1:0] ovf_pulse;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm_timer_pair u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .gate_en(gate_en), .gate_in(gate_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_ovf(input int ch);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ovf_pulse[ch] && n < 70000);
  endtask

  // starts in a cycle with the overflow pulse high, ends at the next such cycle;
  // an optional write is held during cycle index 'at'
  task automatic measure(input int ch, input int at, input logic [1:0] a, input logic [7:0] d,
                         output int hi, output int len);
    hi = 0; len = 0;
    do begin
      wr_en = (len == at); wr_addr = a; wr_data = d;
      if (pwm_out[ch]) hi++;
      len++;
      @(negedge clk);
    end while (!ovf_pulse[ch] && len < 70000);
    wr_en = 1'b0;
  endtask

  task automatic test_reset();
    int hi, len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pwm_out after reset", int'(pwm_out), 0);
    check("R1", "ovf_pulse after reset", int'(ovf_pulse), 0);
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R1", "default overflow period ch0", len, 8192);
    check("R8", "disabled ch0 high cycles", hi, 0);
  endtask

  task automatic test_rates();
    int hi, len;
    wr(2'd1, 8'h40);
    wr(2'd2, 8'h20);
    wr(2'd0, 8'hC8);
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R3", "ch0 period field 0", len, 512);
    check("R4", "ch0 high cycles C=0x40", hi, 128);
    sync_ovf(1);
    measure(1, -1, 2'd3, 8'h00, hi, len);
    check("R2", "ch1 period field 1", len, 1024);
    check("R4", "ch1 high cycles C=0x20", hi, 128);
  endtask

  task automatic test_duty();
    int hi, len;
    wr(2'd1, 8'hFF);
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R4", "ch0 high cycles C=0xFF", hi, 510);
    wr(2'd1, 8'h00);
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R5", "ch0 high cycles C=0x00", hi, 0);
    check("R7", "ch0 period C=0x00", len, 512);
    wr(2'd1, 8'h40);
    sync_ovf(0);
  endtask

  task automatic test_buffer();
    int hi, len;
    sync_ovf(0);
    measure(0, 20, 2'd1, 8'h80, hi, len);
    check("R6", "period with mid-period write keeps old duty", hi, 128);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R6", "next period uses new duty", hi, 256);
  endtask

  task automatic test_coincide();
    int hi, len;
    wr(2'd1, 8'h40);
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    measure(0, 511, 2'd1, 8'h80, hi, len);
    check("R6", "period ending in wrap-edge write", hi, 128);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R6", "wrap-edge write deferred one period", hi, 128);
    measure(0, 510, 2'd1, 8'h40, hi, len);
    check("R6", "period ending with early write", hi, 256);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R6", "write one cycle before wrap applies next", hi, 128);
  endtask

  task automatic test_disable();
    int hi, len;
    wr(2'd0, 8'h88);
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R8", "disabled ch0 high cycles", hi, 0);
    check("R8", "disabled ch0 keeps counting", len, 512);
    sync_ovf(1);
    measure(1, -1, 2'd3, 8'h00, hi, len);
    check("R2", "ch1 still enabled by bit 7", hi, 128);
    wr(2'd0, 8'hC8);
  endtask

  task automatic test_gate();
    int hi, len, bad, ovfs;
    sync_ovf(0);
    repeat (10) @(negedge clk);
    gate_en[0] = 1'b1; gate_in[0] = 1'b0;
    @(negedge clk);
    bad = 0; ovfs = 0;
    for (int k = 0; k < 2000; k++) begin
      if (pwm_out[0] !== 1'b1) bad++;
      if (ovf_pulse[0]) ovfs++;
      @(negedge clk);
    end
    check("R9", "gated ch0 cycles not held high", bad, 0);
    check("R9", "gated ch0 overflow pulses", ovfs, 0);
    gate_in[0] = 1'b1;
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R9", "ch0 high cycles after ungating", hi, 128);
    gate_en[0] = 1'b0; gate_in[0] = 1'b0;
    sync_ovf(0);
    measure(0, -1, 2'd3, 8'h00, hi, len);
    check("R9", "gate input ignored when gating off", len, 512);
    gate_in[0] = 1'b1;
  endtask

  task automatic test_run();
    int bad, ovfs;
    sync_ovf(0);
    repeat (300) @(negedge clk);
    run_en[0] = 1'b0;
    @(negedge clk);
    bad = 0; ovfs = 0;
    for (int k = 0; k < 2000; k++) begin
      if (pwm_out[0] !== 1'b0) bad++;
      if (ovf_pulse[0]) ovfs++;
      @(negedge clk);
    end
    check("R10", "stopped ch0 cycles not held low", bad, 0);
    check("R10", "stopped ch0 overflow pulses", ovfs, 0);
    run_en[0] = 1'b1;
  endtask

  initial begin
    test_reset();
    test_rates();
    test_duty();
    test_buffer();
    test_coincide();
    test_disable();
    test_gate();
    test_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule